// File: doc/BRIEF.md
# Message-Signalled Interrupt Translation Table

This block sits between the inbound side of a PCIe link and the processor's interrupt controller. Each inbound memory write that has already been recognised as an interrupt message arrives as a one-cycle strobe carrying the write address and the low 16 bits of its data. A table of sixteen programmable 32-bit slots decides what the message means. A slot hits when it is enabled, when its 12-bit tag equals address bits 23:12, and when every bit set in its 16-bit pattern is also set in the message data. Each hitting slot raises one of four shared interrupt lines.

The lines are sticky pending flags. Software clears them by writing ones to a status word. A control word can switch the data comparison to big-endian, which swaps the two message data bytes before any slot looks at them. Software programs the slots, the control word and the status word through a simple word-addressed register port. Reads on that port are combinational.

Top module: `msi_xlate_table`

## Requirements
- R1: After reset, every slot reads 0x8000_0000 (disabled, all fields zero), the endian word reads 0, the status word reads 0, and all four interrupt lines are low.
- R2: A write to word index n (0 to 15) stores the 32-bit value into slot n, except that bit 30 is always stored as 0. A read of index n returns the stored value.
- R3: Word index 16 is the endian word. Only bit 0 is kept. A read returns that bit in bit 0, with bits 31:1 as zero.
- R4: A slot whose bit 31 is 1 never raises an interrupt line.
- R5: A slot's tag, in bits 27:16, must equal message address bits 23:12. When they differ, the slot does not hit, and no other address bit matters.
- R6: A slot hits only if every bit set in its pattern (bits 15:0) is also set in the message data. Extra message bits do not prevent a hit.
- R7: When the endian bit is 1, the message data has its two bytes swapped before comparison (data[7:0] compared as the upper byte).
- R8: Slot bits 29:28 select the line (0 to 3) that a hit sets. Several slots may drive the same line, and any one of them sets it.
- R9: A hit on a message strobed in cycle t shows on `irq_pending` from the clock edge that ends cycle t. The line stays high until it is cleared.
- R10: A write to word index 17 clears each line whose bit (3:0) in the write data is 1. Reads of index 17 return the lines in bits 3:0. If a hit and a clear meet on the same line in the same cycle, the line ends up set.
- R11: Writes to word indices 18 to 31 change nothing, and reads of those indices return 0.
- R12: A message uses the slot and endian values held before any register write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Word index for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| msg_valid | input | 1 | Inbound interrupt message strobe |
| msg_addr | input | 32 | Inbound message write address |
| msg_data | input | 16 | Inbound message data |
| irq_pending | output | 4 | Sticky interrupt lines |

## Verification
Two actions can fall in the same clock cycle: a status-word clear of a line, and a message that hits a slot steered to that same line. The bench provokes this directly. It sets a line, then in one cycle writes the clear and strobes a matching message, and expects the line to stay high. The random phase mixes register writes (slots, endian word, clears) with messages in the same cycles. A reference model applies the message against the old table first and the write second, then compares the lines after every cycle.

// File: rtl/msi_xlt_pkg.sv
package msi_xlt_pkg;
  localparam int TAG_W      = 12;
  localparam int PAT_W      = 16;
  localparam int LINE_W     = 2;
  localparam int TAG_MSG_LO = 12;

  // Field order is the register layout software writes.
  typedef struct packed {
    logic              dis;
    logic              rsvd;
    logic [LINE_W-1:0] line;
    logic [TAG_W-1:0]  tag;
    logic [PAT_W-1:0]  pattern;
  } xlt_entry_t;

  localparam xlt_entry_t ENTRY_RESET = '{dis: 1'b1, default: '0};

  function automatic logic [PAT_W-1:0] swap_bytes(input logic [PAT_W-1:0] d);
    return {d[7:0], d[15:8]};
  endfunction

  function automatic xlt_entry_t sanitize(input logic [31:0] w);
    xlt_entry_t e;
    e      = xlt_entry_t'(w);
    e.rsvd = 1'b0;
    return e;
  endfunction

  // Every pattern bit must be present in the message data.
  function automatic logic entry_hits(input xlt_entry_t e,
                                      input logic [TAG_W-1:0] tag,
                                      input logic [PAT_W-1:0] d);
    return !e.dis && (e.tag == tag) && ((e.pattern & ~d) == '0);
  endfunction
endpackage

// File: rtl/msi_xlt_entry.sv
module msi_xlt_entry
  import msi_xlt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [31:0]          wdata,
  input  logic                 msg_valid,
  input  logic [TAG_W-1:0]     msg_tag,
  input  logic [PAT_W-1:0]     msg_data,
  output xlt_entry_t           entry_q,
  output logic                 hit,
  output logic [LINE_W-1:0]    line
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     entry_q <= ENTRY_RESET;
    else if (wr_en) entry_q <= sanitize(wdata);
  end

  assign hit  = msg_valid && entry_hits(entry_q, msg_tag, msg_data);
  assign line = entry_q.line;

  // R2: a write lands with bit 30 forced low
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (entry_q[31] == $past(wdata[31])) && !entry_q[30] &&
              (entry_q[29:0] == $past(wdata[29:0])));

  // R4: a disabled slot stays silent
  a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    entry_q.dis |-> !hit);
endmodule

// File: rtl/msi_xlt_steer.sv
module msi_xlt_steer
  import msi_xlt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_LINES   = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_ENTRIES-1:0]                hit,
  input  logic [NUM_ENTRIES-1:0][LINE_W-1:0]    line_sel,
  input  logic [NUM_LINES-1:0]                  clr,
  output logic [NUM_LINES-1:0]                  pend
);
  logic [NUM_LINES-1:0] line_set;

  always_comb begin
    line_set = '0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (hit[i]) line_set[line_sel[i]] = 1'b1;
  end

  // Set wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | line_set;
  end

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_chk
    // R9: a line rises only after a hit steered to it
    a_r9_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[k]) |-> $past(line_set[k]));
    // R9: a line holds while not cleared
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[k] && !clr[k]) |=> pend[k]);
    // R10: same-cycle hit beats clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      line_set[k] |=> pend[k]);
    // R10: clear without hit drops the line
    a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[k] && !line_set[k]) |=> !pend[k]);
  end
endmodule

// File: rtl/msi_xlate_table.sv
module msi_xlate_table
  import msi_xlt_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_LINES   = 4,
  parameter int CFG_AW      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              msg_valid,
  input  logic [31:0]       msg_addr,
  input  logic [15:0]       msg_data,
  output logic [3:0]        irq_pending
);
  localparam int IDX_W      = $clog2(NUM_ENTRIES);
  localparam int ENDIAN_IDX = NUM_ENTRIES;
  localparam int STATUS_IDX = NUM_ENTRIES + 1;

  xlt_entry_t                            ent_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0]                ent_hit;
  logic [NUM_ENTRIES-1:0][LINE_W-1:0]    ent_line;
  logic                                  endian_q;
  logic [PAT_W-1:0]                      data_eff;
  logic [TAG_W-1:0]                      msg_tag;
  logic [NUM_LINES-1:0]                  clr_lines;
  logic [NUM_LINES-1:0]                  pend;
  logic                                  wr_endian, wr_status;
  logic                                  unused_addr_bits;

  assign msg_tag          = msg_addr[TAG_MSG_LO +: TAG_W];
  assign unused_addr_bits = ^{msg_addr[31:24], msg_addr[11:0], cfg_wdata[31:NUM_LINES]};
  assign data_eff         = endian_q ? swap_bytes(msg_data) : msg_data;
  assign wr_endian        = cfg_wr && (cfg_addr == CFG_AW'(ENDIAN_IDX));
  assign wr_status        = cfg_wr && (cfg_addr == CFG_AW'(STATUS_IDX));
  assign clr_lines        = wr_status ? cfg_wdata[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         endian_q <= 1'b0;
    else if (wr_endian) endian_q <= cfg_wdata[0];
  end

  for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_ent
    msi_xlt_entry u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr && (cfg_addr == CFG_AW'(n))),
      .wdata     (cfg_wdata),
      .msg_valid (msg_valid),
      .msg_tag   (msg_tag),
      .msg_data  (data_eff),
      .entry_q   (ent_q[n]),
      .hit       (ent_hit[n]),
      .line      (ent_line[n])
    );
  end

  msi_xlt_steer #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_LINES(NUM_LINES)) u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (ent_hit),
    .line_sel (ent_line),
    .clr      (clr_lines),
    .pend     (pend)
  );

  assign irq_pending = pend;

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr < CFG_AW'(NUM_ENTRIES))   cfg_rdata = ent_q[cfg_addr[IDX_W-1:0]];
    else if (cfg_addr == CFG_AW'(ENDIAN_IDX)) cfg_rdata = {31'd0, endian_q};
    else if (cfg_addr == CFG_AW'(STATUS_IDX)) cfg_rdata = {{(32-NUM_LINES){1'b0}}, pend};
  end

  // R3: endian word exposes only bit 0
  a_r3_endian_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == CFG_AW'(ENDIAN_IDX)) |-> (cfg_rdata[31:1] == '0));
  // R3: endian bit follows its write
  a_r3_endian_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_endian |=> (endian_q == $past(cfg_wdata[0])));
  // R11: unmapped indices read as zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr > CFG_AW'(STATUS_IDX)) |-> (cfg_rdata == '0));
  // R2: no slot ever reads back bit 30
  a_r2_rsvd_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr < CFG_AW'(NUM_ENTRIES)) |-> !cfg_rdata[30]);
endmodule

// File: tb/msi_xlate_table_test.sv
module msi_xlate_table_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        msg_valid = 1'b0;
  logic [31:0] msg_addr = '0;
  logic [15:0] msg_data = '0;
  logic [3:0]  irq_pending;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_tab [16];
  logic        m_end;
  logic [3:0]  m_pend;

  always #10 clk = ~clk;

  msi_xlate_table uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data), .irq_pending(irq_pending)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  // Reference: which lines a message sets against the current model.
  function automatic logic [3:0] ref_lines(input logic [31:0] a, input logic [15:0] d);
    logic [15:0] seen;
    logic [3:0]  r;
    seen = m_end ? {d[7:0], d[15:8]} : d;
    r = '0;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] e;
      e = m_tab[i];
      if (e[31] == 1'b0 && e[27:16] == a[23:12] && ((e[15:0] | seen) == seen))
        r[e[29:28]] = 1'b1;
    end
    return r;
  endfunction

  // One clock cycle with an optional write and an optional message.
  task automatic cycle(input bit dw, input logic [4:0] wa, input logic [31:0] wd,
                       input bit dm, input logic [31:0] ma, input logic [15:0] md);
    logic [3:0] hits;
    logic [3:0] clr;
    @(negedge clk);
    cfg_wr = dw; cfg_addr = wa; cfg_wdata = wd;
    msg_valid = dm; msg_addr = ma; msg_data = md;
    hits = dm ? ref_lines(ma, md) : 4'd0;
    clr = '0;
    if (dw) begin
      if (wa < 5'd16) m_tab[wa[3:0]] = wd & 32'hBFFF_FFFF;
      else if (wa == 5'd16) m_end = wd[0];
      else if (wa == 5'd17) clr = wd[3:0];
    end
    m_pend = (m_pend & ~clr) | hits;
    @(negedge clk);
    cfg_wr = 1'b0; msg_valid = 1'b0;
    #1;
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  function automatic logic [31:0] mk(input bit dis, input int ln, input logic [11:0] tag,
                                     input logic [15:0] pat);
    return {dis, 1'b0, 2'(ln), tag, pat};
  endfunction

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] tags [3];
    void'($urandom(32'd20240611));
    tags[0] = 12'h0AB; tags[1] = 12'h3C4; tags[2] = 12'h7FF;
    for (int i = 0; i < 16; i++) m_tab[i] = 32'h8000_0000;
    m_end = 1'b0; m_pend = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd("R1 slot0", 5'd0, 32'h8000_0000);
    rd("R1 slot15", 5'd15, 32'h8000_0000);
    rd("R1 endian", 5'd16, 32'd0);
    rd("R1 status", 5'd17, 32'd0);
    chk("R1 irq", {28'd0, irq_pending}, 32'd0);

    // R2 write with bit 30 set, read back with it cleared
    cycle(1, 5'd3, mk(0, 1, 12'hABC, 16'h0008) | 32'h4000_0000, 0, 0, 0);
    rd("R2 readback", 5'd3, mk(0, 1, 12'hABC, 16'h0008));
    // R6 R8 R9 hit sets line 1 after one edge; other address bits ignored (R5)
    cycle(0, 0, 0, 1, 32'hFFAB_CFFF, 16'h0008);
    chk("R9 line1 set", {28'd0, irq_pending}, 32'h2);
    cycle(0, 0, 0, 0, 0, 0);
    chk("R9 sticky", {28'd0, irq_pending}, 32'h2);
    rd("R10 status read", 5'd17, 32'h2);
    // R10 clear
    cycle(1, 5'd17, 32'hFFFF_FFF2, 0, 0, 0);
    chk("R10 cleared", {28'd0, irq_pending}, 32'h0);
    // R5 tag mismatch
    cycle(0, 0, 0, 1, 32'h00AB_D000, 16'hFFFF);
    chk("R5 tag mismatch", {28'd0, irq_pending}, 32'h0);
    // R6 missing pattern bit; extra bits allowed
    cycle(0, 0, 0, 1, 32'h00AB_C000, 16'hFFF7);
    chk("R6 missing bit", {28'd0, irq_pending}, 32'h0);
    cycle(0, 0, 0, 1, 32'h00AB_C000, 16'h00FF);
    chk("R6 extra bits", {28'd0, irq_pending}, 32'h2);
    cycle(1, 5'd17, 32'hF, 0, 0, 0);
    // R4 disabled slot
    cycle(1, 5'd5, mk(1, 0, 12'h111, 16'h0020), 0, 0, 0);
    cycle(0, 0, 0, 1, 32'h0011_1000, 16'hFFFF);
    chk("R4 disabled", {28'd0, irq_pending}, 32'h0);
    // R3 endian word, R7 swap
    cycle(1, 5'd16, 32'hFFFF_FFFF, 0, 0, 0);
    rd("R3 endian read", 5'd16, 32'd1);
    cycle(0, 0, 0, 1, 32'h00AB_C000, 16'h0008);
    chk("R7 unswapped misses", {28'd0, irq_pending}, 32'h0);
    cycle(0, 0, 0, 1, 32'h00AB_C000, 16'h0800);
    chk("R7 swapped hits", {28'd0, irq_pending}, 32'h2);
    cycle(1, 5'd16, 32'h0, 0, 0, 0);
    // R10 same-cycle clear and hit on line 1
    cycle(1, 5'd17, 32'h2, 1, 32'h00AB_C000, 16'h0008);
    chk("R10 set wins", {28'd0, irq_pending}, 32'h2);
    cycle(1, 5'd17, 32'hF, 0, 0, 0);
    // R8 two slots share line 2
    cycle(1, 5'd7, mk(0, 2, 12'h222, 16'h0080), 0, 0, 0);
    cycle(1, 5'd9, mk(0, 2, 12'h333, 16'h0200), 0, 0, 0);
    cycle(0, 0, 0, 1, 32'h0033_3000, 16'h0200);
    chk("R8 shared line b", {28'd0, irq_pending}, 32'h4);
    cycle(1, 5'd17, 32'h4, 0, 0, 0);
    cycle(0, 0, 0, 1, 32'h0022_2000, 16'h0080);
    chk("R8 shared line a", {28'd0, irq_pending}, 32'h4);
    // R12 write and message same cycle: message sees old slot
    cycle(1, 5'd7, mk(1, 2, 12'h222, 16'h0080), 1, 32'h0022_2000, 16'h0080);
    chk("R12 old slot used", {28'd0, irq_pending}, 32'h4);
    cycle(1, 5'd17, 32'hF, 1, 32'h0022_2000, 16'h0080);
    chk("R12 new slot used", {28'd0, irq_pending}, 32'h0);
    // R11 unmapped write ignored
    cycle(1, 5'd20, 32'hFFFF_FFFF, 0, 0, 0);
    rd("R11 unmapped read", 5'd20, 32'd0);
    rd("R11 slot intact", 5'd3, mk(0, 1, 12'hABC, 16'h0008));
    rd("R11 endian intact", 5'd16, 32'd0);

    // Random phase
    for (int it = 0; it < 600; it++) begin
      bit          dw, dm;
      logic [4:0]  wa;
      logic [31:0] wd, ma;
      logic [15:0] md;
      int          sel;
      sel = $urandom_range(0, 99);
      dw = ($urandom_range(0, 2) != 0);
      if (sel < 65) begin
        wa = 5'($urandom_range(0, 15));
        wd = mk($urandom_range(0, 4) == 0, $urandom_range(0, 3),
                tags[$urandom_range(0, 2)],
                ($urandom_range(0, 5) == 0) ? 16'($urandom) :
                  (16'd1 << $urandom_range(0, 15)));
        wd[30] = 1'($urandom);
      end else if (sel < 75) begin
        wa = 5'd16; wd = $urandom;
      end else if (sel < 93) begin
        wa = 5'd17; wd = $urandom;
      end else begin
        wa = 5'($urandom_range(18, 31)); wd = $urandom;
      end
      dm = ($urandom_range(0, 1) != 0);
      ma = $urandom;
      if ($urandom_range(0, 3) != 0) ma[23:12] = tags[$urandom_range(0, 2)];
      md = 16'($urandom);
      cycle(dw, wa, wd, dm, ma, md);
      chk("R9 random lines", {28'd0, irq_pending}, {28'd0, m_pend});
      begin
        logic [4:0] ra;
        ra = 5'($urandom_range(0, 31));
        if (ra < 5'd16)       rd("R2 random read", ra, m_tab[ra[3:0]]);
        else if (ra == 5'd16) rd("R3 random read", ra, {31'd0, m_end});
        else if (ra == 5'd17) rd("R10 random read", ra, {28'd0, m_pend});
        else                  rd("R11 random read", ra, 32'd0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule